// File: doc/BRIEF.md
# Adaptive Interrupt Rate Pacer

This block sits between a stream of single-cycle event requests, such as receive-completion pulses, and a CPU interrupt line. After every acknowledged interrupt it holds back the next one for a delay counted in prescaler ticks. It then keeps adjusting that delay so the delivered interrupt rate follows a programmed target, given in interrupts per millisecond.

A free-running prescaler divides the clock into ticks. With the default divide and a 100 MHz clock, one tick is 4 µs. A window of 250 ticks (1 ms) counts the interrupts issued. At the end of each window the delay is moved by one of five actions, chosen by comparing that count with thresholds taken from the target.

A burst that exceeds twice the target inside a window forces a hold at the saturation limit and starts a fresh window. An idle block passes the first event through after a single clock. Writing a target of zero turns pacing off.

Top module: `irq_pacer`

## Requirements
- R1: After reset, irq_out is 0, cur_delay is 0 and win_count is 0.
- R2: When no hold is running and irq_out is low, an event on event_in raises irq_out at the next rising clock edge.
- R3: irq_out stays high until irq_ack is sampled high with it, and falls at that edge. Any number of events that arrive while irq_out is high, or while a hold runs, merge into exactly one further interrupt.
- R4: An acknowledge loads the hold with cur_delay ticks. No new interrupt is raised until the hold has counted down to zero.
- R5: win_count reports the interrupts issued in the current window of 250 ticks. It returns to 0, or to 1 if an interrupt fires at that edge, when the window ends. cur_delay changes only at a window end, an overrun, or while pacing is off.
- R6: At a window end with count C and target T: if C > T and 2C <= 3T, the delay grows by one tick; if T <= 2C and C < T, it shrinks by one tick (never below 0).
- R7: At a window end, 2C > 3T doubles the delay (0 becomes 1, capped at 256). 2C < T halves it, rounding down.
- R8: At a window end with C = T the delay is unchanged. cur_delay never exceeds 256 ticks.
- R9: If the target is nonzero and an interrupt is due while the window count already equals 2T, it is not raised. Instead cur_delay and the hold become 256 ticks, win_count clears, the window restarts, and the interrupt is raised once the hold expires.
- R10: A target of 0 disables pacing. cur_delay is forced to 0 on the next edge, and every event raises irq_out on the next clock once the previous interrupt has been acknowledged, with no hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| event_in | input | 1 | Event request, one pulse per event |
| irq_ack | input | 1 | Software acknowledge of irq_out |
| target_rate | input | 8 | Target interrupts per millisecond, 0 disables pacing |
| irq_out | output | 1 | Interrupt line, level, held until acknowledged |
| cur_delay | output | 9 | Current delay step in ticks (0 to 256) |
| win_count | output | 10 | Interrupts issued in the current window |

## Verification
The interrupt edge is due one clock after an event when no hold is running, and its fall is due one clock after an acknowledge. The bench drives these stimuli at a falling edge and compares at the next falling edge. Delay updates only become visible at window boundaries, so the bench does not count cycles from reset. It instead waits for win_count to return to zero, compares cur_delay at that falling edge, and then starts the next window's stimulus at once. The saturation hold spans 256 ticks at a two-clock tick, and the prescaler phase shifts when that hold ends by a cycle or two. The bench therefore accepts the released interrupt inside a window of 500 to 520 clocks and requires it to be absent well before that.

// File: rtl/irq_pacer_pkg.sv
package irq_pacer_pkg;

    typedef enum logic [2:0] {
        ADJ_KEEP,
        ADJ_SAT,
        ADJ_DOUBLE,
        ADJ_INC,
        ADJ_DEC,
        ADJ_HALF
    } adj_e;

    // Selects the window-end action from the issued count and the target.
    function automatic adj_e pick_adj(input int unsigned cnt, input int unsigned rate);
        if (2 * cnt > 3 * rate)
            return ADJ_DOUBLE;
        else if (cnt > rate)
            return ADJ_INC;
        else if (2 * cnt < rate)
            return ADJ_HALF;
        else if (cnt < rate)
            return ADJ_DEC;
        else
            return ADJ_KEEP;
    endfunction

    // Applies an action to a delay, keeping the result inside 0..sat.
    function automatic int unsigned apply_adj(input adj_e act, input int unsigned d,
                                              input int unsigned sat);
        int unsigned r;
        case (act)
            ADJ_SAT:    r = sat;
            ADJ_DOUBLE: r = (d == 0) ? 1 : 2 * d;
            ADJ_INC:    r = d + 1;
            ADJ_DEC:    r = (d == 0) ? 0 : d - 1;
            ADJ_HALF:   r = d >> 1;
            default:    r = d;
        endcase
        return (r > sat) ? sat : r;
    endfunction

endpackage

// File: rtl/pacer_prescaler.sv
module pacer_prescaler #(
    parameter int DIV = 400
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst)
                    cnt_q <= '0;
                else if (cnt_q == CW'(DIV - 1))
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
            assign tick = (cnt_q == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/pacer_gate.sv
module pacer_gate #(
    parameter int DLY_W     = 9,
    parameter int SAT_TICKS = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             event_in,
    input  logic             irq_ack,
    input  logic             en,
    input  logic             sat_now,
    input  logic [DLY_W-1:0] delay,
    output logic             want,
    output logic             fire,
    output logic             irq_out
);
    logic [DLY_W-1:0] hold_q;
    logic             pend_q;
    logic             irq_q;
    logic             acked;

    assign acked   = irq_q && irq_ack;
    assign want    = !irq_q && (pend_q || event_in) && (hold_q == '0 || !en);
    assign fire    = want && !sat_now;
    assign irq_out = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            pend_q <= 1'b0;
            hold_q <= '0;
        end else begin
            if (fire)
                irq_q <= 1'b1;
            else if (acked)
                irq_q <= 1'b0;

            if (fire)
                pend_q <= 1'b0;
            else if (event_in)
                pend_q <= 1'b1;

            if (sat_now)
                hold_q <= DLY_W'(SAT_TICKS);
            else if (acked)
                hold_q <= en ? delay : '0;
            else if (!en)
                hold_q <= '0;
            else if (tick && hold_q != '0)
                hold_q <= hold_q - 1'b1;
        end
    end

    // R4: a new interrupt only rises once the hold has run out (or pacing is off)
    assert_rise_after_hold_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(hold_q == '0 || !en));

    // R3: the line is held until acknowledged
    assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !irq_ack) |=> irq_q);

    // R3: an acknowledge drops the line at that edge
    assert_ack_drops_R3: assert property (@(posedge clk) disable iff (rst)
        (irq_q && irq_ack) |=> !irq_q);

endmodule

// File: rtl/pacer_adapt.sv
module pacer_adapt
    import irq_pacer_pkg::*;
#(
    parameter int RATE_W       = 8,
    parameter int CNT_W        = 10,
    parameter int DLY_W        = 9,
    parameter int WINDOW_TICKS = 250,
    parameter int SAT_TICKS    = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    input  logic              want,
    input  logic              fire,
    output logic              en,
    output logic              sat_now,
    output logic [DLY_W-1:0]  delay,
    output logic [CNT_W-1:0]  count
);
    localparam int WIN_W = (WINDOW_TICKS > 1) ? $clog2(WINDOW_TICKS) : 1;

    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DLY_W-1:0] dly_q;
    logic [CNT_W-1:0] limit;
    logic             win_end;
    adj_e             act;

    assign en      = (rate != '0);
    assign limit   = CNT_W'({rate, 1'b0});
    assign sat_now = en && want && (cnt_q >= limit);
    assign win_end = en && tick && (win_q == WIN_W'(WINDOW_TICKS - 1));
    assign act     = pick_adj(32'(cnt_q), 32'(rate));
    assign delay   = dly_q;
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            win_q <= '0;
            cnt_q <= '0;
            dly_q <= '0;
        end else if (sat_now) begin
            win_q <= '0;
            cnt_q <= '0;
            dly_q <= DLY_W'(apply_adj(ADJ_SAT, 32'(dly_q), SAT_TICKS));
        end else begin
            if (tick)
                win_q <= win_end ? '0 : win_q + 1'b1;
            if (win_end) begin
                cnt_q <= fire ? CNT_W'(1) : '0;
                dly_q <= DLY_W'(apply_adj(act, 32'(dly_q), SAT_TICKS));
            end else if (fire) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R8: the delay never leaves its clamp range
    assert_delay_clamp_R8: assert property (@(posedge clk) disable iff (rst)
        dly_q <= DLY_W'(SAT_TICKS));

    // R9: an overrun installs the saturation delay and clears the window count
    assert_overrun_sat_R9: assert property (@(posedge clk) disable iff (rst)
        sat_now |=> (dly_q == DLY_W'(SAT_TICKS)) && (cnt_q == '0));

    // R10: pacing off forces the delay to zero
    assert_disabled_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (dly_q == '0));

    // R5: the delay only moves at a window end, an overrun, or when disabled
    assert_delay_moves_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(dly_q) |-> $past(win_end || sat_now || !en));

endmodule

// File: rtl/irq_pacer.sv
module irq_pacer #(
    parameter int PRESCALE_DIV = 400,
    parameter int RATE_W       = 8,
    parameter int WINDOW_TICKS = 250,
    parameter int SAT_TICKS    = 256,
    localparam int DLY_W       = $clog2(SAT_TICKS + 1),
    localparam int CNT_W       = RATE_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              event_in,
    input  logic              irq_ack,
    input  logic [RATE_W-1:0] target_rate,
    output logic              irq_out,
    output logic [DLY_W-1:0]  cur_delay,
    output logic [CNT_W-1:0]  win_count
);
    logic             tick;
    logic             en;
    logic             want;
    logic             fire;
    logic             sat_now;
    logic [DLY_W-1:0] delay;
    logic [CNT_W-1:0] count;

    pacer_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    pacer_adapt #(
        .RATE_W       (RATE_W),
        .CNT_W        (CNT_W),
        .DLY_W        (DLY_W),
        .WINDOW_TICKS (WINDOW_TICKS),
        .SAT_TICKS    (SAT_TICKS)
    ) u_adapt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .rate    (target_rate),
        .want    (want),
        .fire    (fire),
        .en      (en),
        .sat_now (sat_now),
        .delay   (delay),
        .count   (count)
    );

    pacer_gate #(
        .DLY_W     (DLY_W),
        .SAT_TICKS (SAT_TICKS)
    ) u_gate (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .event_in (event_in),
        .irq_ack  (irq_ack),
        .en       (en),
        .sat_now  (sat_now),
        .delay    (delay),
        .want     (want),
        .fire     (fire),
        .irq_out  (irq_out)
    );

    assign cur_delay = delay;
    assign win_count = count;

    // R1: all outputs are quiet on the edge after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!irq_out && cur_delay == '0 && win_count == '0));

endmodule

// File: tb/irq_pacer_test.sv
module irq_pacer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       event_in = 1'b0;
    logic       irq_ack = 1'b0;
    logic [7:0] target_rate = 8'd4;
    logic       irq_out;
    logic [8:0] cur_delay;
    logic [9:0] win_count;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        string tag;
        int    got;
        int    exp;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    irq_pacer #(.PRESCALE_DIV(2)) uut (
        .clk         (clk),
        .rst         (rst),
        .event_in    (event_in),
        .irq_ack     (irq_ack),
        .target_rate (target_rate),
        .irq_out     (irq_out),
        .cur_delay   (cur_delay),
        .win_count   (win_count)
    );

    // driver side: queue an observation with its expected value
    task automatic expect_eq(input string tag, input int got, input int exp);
        item_t it;
        it.tag = tag;
        it.got = got;
        it.exp = exp;
        sb_q.push_back(it);
    endtask

    // monitor side: drain and compare
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (it.got != it.exp) begin
                n_bad++;
                $display("FAIL %s: got %0d expected %0d", it.tag, it.got, it.exp);
            end
        end
    end

    // one event, waited on until the interrupt appears, then acknowledged
    task automatic serve(output int lat);
        event_in = 1'b1;
        @(negedge clk);
        event_in = 1'b0;
        lat = 1;
        while (!irq_out && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic serve_n(input int n);
        for (int i = 0; i < n; i++) begin
            int l;
            serve(l);
        end
    endtask

    task automatic wait_window_end;
        int guard = 0;
        while (win_count != 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic finish_run;
        @(negedge clk);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_eq("R1 irq_out after reset", irq_out, 0);
        expect_eq("R1 cur_delay after reset", cur_delay, 0);
        expect_eq("R1 win_count after reset", win_count, 0);

        // window 0: target 4, five interrupts -> increment
        serve(lat);
        expect_eq("R2 idle first event latency", lat, 1);
        expect_eq("R3 irq_out low after ack", irq_out, 0);
        serve_n(4);
        expect_eq("R5 win_count after five interrupts", win_count, 5);
        wait_window_end();
        expect_eq("R6 increment on C=5 T=4", cur_delay, 1);

        // window 1: seven interrupts -> double
        serve(lat);
        expect_eq("R2 first event of window latency", lat, 1);
        serve_n(6);
        wait_window_end();
        expect_eq("R7 double on C=7 T=4", cur_delay, 2);

        // window 2: four interrupts -> unchanged
        serve_n(4);
        wait_window_end();
        expect_eq("R8 keep on C=T", cur_delay, 2);

        // window 3: three interrupts -> decrement
        serve_n(3);
        wait_window_end();
        expect_eq("R6 decrement on C=3 T=4", cur_delay, 1);

        // window 4: one interrupt -> halve
        serve_n(1);
        wait_window_end();
        expect_eq("R7 halve on C=1 T=4", cur_delay, 0);

        // window 5: eight interrupts, the ninth trips the overrun
        serve_n(8);
        expect_eq("R5 win_count at twice target", win_count, 8);
        event_in = 1'b1;
        @(negedge clk);
        event_in = 1'b0;
        expect_eq("R9 overrun holds irq_out low", irq_out, 0);
        expect_eq("R9 overrun saturates delay", cur_delay, 256);
        expect_eq("R9 overrun clears window count", win_count, 0);
        lat = 1;
        while (!irq_out && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        expect_eq("R4 R9 held interrupt released after 256 ticks",
                  (lat >= 500 && lat <= 520) ? 1 : 0, 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;

        // pacing off
        target_rate = 8'd0;
        @(negedge clk);
        expect_eq("R10 delay forced to zero", cur_delay, 0);
        serve(lat);
        expect_eq("R10 disabled latency", lat, 1);
        serve(lat);
        expect_eq("R10 back-to-back no hold", lat, 1);

        // merge: events while irq_out is high
        event_in = 1'b1;
        @(negedge clk);
        expect_eq("R3 irq raised", irq_out, 1);
        @(negedge clk);
        @(negedge clk);
        event_in = 1'b0;
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        expect_eq("R3 dropped on ack", irq_out, 0);
        @(negedge clk);
        expect_eq("R3 merged events give one interrupt", irq_out, 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        repeat (5) @(negedge clk);
        expect_eq("R3 no further interrupt after merge", irq_out, 0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule